// File: doc/BRIEF.md
# Fixed-Point Thermal Averaging Filter

This block turns a stream of signed whole-degree temperature readings into a smoothed running value. Each reading is an integer step of roughly one degree Celsius. It is measured relative to the point where thermal throttling engages, so a reading of zero means the die sits at that point. The filter is a first-order recursive (exponential) average. A 3-bit shift sets its time constant, so a system can choose between a smoother result with more lag and a faster result with less smoothing.

The result is a 16-bit two's-complement fixed-point number: 10 integer bits above 6 fraction bits. Because the input is referenced to the throttle point, an averaged value strictly between 0 and 1 can only arise when part of the averaging window was spent at or below that point, which is where throttling acts. A dedicated flag reports that condition. The accumulator takes the first reading after reset exactly, and it clips rather than wrapping.

Top module: `thermal_avg_filter`

## Requirements
- R1: During reset and after it, until the first valid reading, `avg_q` is 0 and `window_throttled` is 0.
- R2: The first reading accepted after reset loads `avg_q` with the reading times 64 exactly, for any value of `shift_k`.
- R3: Each later accepted reading updates `avg_q` to avg + ((reading*64 - avg) >>> shift_k). The shift is arithmetic (it rounds toward minus infinity) and `shift_k` ranges from 0 to 7. With `shift_k` = 0 the result equals the reading times 64.
- R4: From the same starting value and for the same reading, a larger `shift_k` gives a step of equal or smaller size, and the new value lies no further from the old one.
- R5: While `sample_vld` is low, `avg_q` holds its value, whatever `sample_in` and `shift_k` carry.
- R6: `window_throttled` is 1 exactly when `avg_q`, read as signed with bits 5:0 as the fraction, is greater than 0 and less than 64 (1.0). It follows `avg_q` in the same cycle.
- R7: Starting from a value in (0,1), repeated readings of 0 make `avg_q` strictly decrease on every accepted reading until it reaches exactly 0.
- R8: `avg_q` never wraps. After each accepted reading it lies between the previous value and the reading times 64, inclusive, and it is clipped to the range -32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Reading valid strobe, one reading per high cycle |
| sample_in | input | 10 | Signed integer reading relative to the throttle point |
| shift_k | input | 3 | Averaging shift, 0 (no smoothing) to 7 (heaviest) |
| avg_q | output | 16 | Signed averaged value, 6 fraction bits |
| window_throttled | output | 1 | Averaged value lies strictly between 0 and 1 |

## Verification
The assertions assume that `sample_in` and `shift_k` are known whenever `sample_vld` is high. They also assume that a reading is treated as a signed 10-bit integer, so the reading times 64 always fits the 16-bit range. The stimulus changes inputs only at falling clock edges and drives `sample_vld` only after reset has been released. It uses readings from -512 to 511 and every shift value, so the bound and range checks are exercised at both ends.

// File: rtl/tavg_pkg.sv
package tavg_pkg;
   typedef enum logic {
      FILL_EMPTY = 1'b0,
      FILL_RUN   = 1'b1
   } fill_e;
endpackage

// File: rtl/tavg_step.sv
// Computes the target (reading scaled to fixed point) and the unclipped next
// value of the recursive average in a widened signed domain.
module tavg_step #(
   parameter int SAMPLE_W    = 10,
   parameter int FRAC_W      = 6,
   parameter int ACC_W       = 16,
   parameter int SHIFT_W     = 3,
   parameter int FIXED_SHIFT = -1
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic signed [ACC_W-1:0]    acc,
   input  logic        [SHIFT_W-1:0]  k,
   output logic signed [ACC_W+1:0]    target,
   output logic signed [ACC_W+1:0]    next_wide
);
   localparam int XW = ACC_W + 2;

   logic signed [XW-1:0]      smp_x, acc_x, diff, step;
   logic        [SHIFT_W-1:0] shamt;

   generate
      if (FIXED_SHIFT < 0) begin : g_prog_shift
         assign shamt = k;
      end else begin : g_const_shift
         logic unused_k;
         assign unused_k = ^k;
         assign shamt    = SHIFT_W'(FIXED_SHIFT);
      end
   endgenerate

   assign smp_x     = {{(XW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
   assign acc_x     = {{(XW-ACC_W){acc[ACC_W-1]}}, acc};
   assign target    = smp_x <<< FRAC_W;
   assign diff      = target - acc_x;
   assign step      = diff >>> shamt;
   assign next_wide = acc_x + step;
endmodule

// File: rtl/tavg_sat.sv
// Clips a wide signed value into a narrower signed range.
module tavg_sat #(
   parameter int IN_W  = 18,
   parameter int OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam logic signed [IN_W-1:0] HI =
      $signed({{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
   localparam logic signed [IN_W-1:0] LO =
      $signed({{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});

   always_comb begin
      if (din > HI)      dout = HI[OUT_W-1:0];
      else if (din < LO) dout = LO[OUT_W-1:0];
      else               dout = din[OUT_W-1:0];
   end
endmodule

// File: rtl/tavg_window_flag.sv
// Flags an averaged value in the open interval (0, 1).
module tavg_window_flag #(
   parameter int ACC_W  = 16,
   parameter int FRAC_W = 6
) (
   input  logic signed [ACC_W-1:0] avg,
   output logic                    in_window
);
   logic int_zero, frac_nz;

   assign int_zero  = (avg[ACC_W-1:FRAC_W] == '0);
   assign frac_nz   = |avg[FRAC_W-1:0];
   assign in_window = int_zero & frac_nz;
endmodule

// File: rtl/thermal_avg_filter.sv
module thermal_avg_filter #(
   parameter int SAMPLE_W    = 10,
   parameter int FRAC_W      = 6,
   parameter int SHIFT_W     = 3,
   parameter int FIXED_SHIFT = -1,
   localparam int ACC_W      = SAMPLE_W + FRAC_W,
   localparam int XW         = ACC_W + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_vld,
   input  logic signed [SAMPLE_W-1:0] sample_in,
   input  logic        [SHIFT_W-1:0]  shift_k,
   output logic signed [ACC_W-1:0]    avg_q,
   output logic                       window_throttled
);
   import tavg_pkg::*;

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample_w
         $error("SAMPLE_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac_w
         $error("FRAC_W must be at least 1");
      end
      if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_shift_w
         $error("SHIFT_W must lie in 1..5");
      end
      if (FIXED_SHIFT >= (1 << SHIFT_W)) begin : g_bad_fixed
         $error("FIXED_SHIFT does not fit SHIFT_W");
      end
   endgenerate

   fill_e                  fill_q;
   logic signed [XW-1:0]   target_w, update_w, pick_w;
   logic signed [ACC_W-1:0] clip_d;

   tavg_step #(
      .SAMPLE_W   (SAMPLE_W),
      .FRAC_W     (FRAC_W),
      .ACC_W      (ACC_W),
      .SHIFT_W    (SHIFT_W),
      .FIXED_SHIFT(FIXED_SHIFT)
   ) u_step (
      .sample   (sample_in),
      .acc      (avg_q),
      .k        (shift_k),
      .target   (target_w),
      .next_wide(update_w)
   );

   assign pick_w = (fill_q == FILL_EMPTY) ? target_w : update_w;

   tavg_sat #(.IN_W(XW), .OUT_W(ACC_W)) u_sat (
      .din (pick_w),
      .dout(clip_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= FILL_EMPTY;
         avg_q  <= '0;
      end else if (sample_vld) begin
         fill_q <= FILL_RUN;
         avg_q  <= clip_d;
      end
   end

   tavg_window_flag #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_flag (
      .avg      (avg_q),
      .in_window(window_throttled)
   );

   // Assertions
   logic signed [XW-1:0] tgt_now;
   logic signed [XW-1:0] avg_x;
   assign tgt_now = {{(XW-SAMPLE_W){sample_in[SAMPLE_W-1]}}, sample_in} <<< FRAC_W;
   assign avg_x   = {{(XW-ACC_W){avg_q[ACC_W-1]}}, avg_q};

   a_r1_empty_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == FILL_EMPTY) |-> (avg_q == '0 && !window_throttled));

   a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == FILL_EMPTY && sample_vld) |=> (avg_x == $past(tgt_now)));

   a_r3_k0_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && shift_k == '0) |=> (avg_x == $past(tgt_now)));

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_vld |=> $stable(avg_q));

   a_r6_flag_range: assert property (@(posedge clk) disable iff (!rst_n)
      window_throttled |-> (avg_q > 0 && avg_q < (1 <<< FRAC_W)));

   a_r8_bounded_up: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && fill_q == FILL_RUN && tgt_now >= avg_x)
      |=> (avg_x >= $past(avg_x) && avg_x <= $past(tgt_now)));

   a_r8_bounded_down: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && fill_q == FILL_RUN && tgt_now < avg_x)
      |=> (avg_x <= $past(avg_x) && avg_x >= $past(tgt_now)));
endmodule

// File: tb/sim_thermal_avg_filter.sv
module sim_thermal_avg_filter;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sample_vld = 1'b0;
   logic signed [9:0] sample_in = '0;
   logic        [2:0] shift_k = '0;
   logic signed [15:0] avg_q;
   logic              window_throttled;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   thermal_avg_filter u0 (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
      .sample_in(sample_in), .shift_k(shift_k),
      .avg_q(avg_q), .window_throttled(window_throttled)
   );

   localparam int NV = 14;
   localparam int VS [NV] = '{20, 40, 40, 0, -1, 0, 0, 1, 1, -5, 1, 511, -512, -512};
   localparam int VK [NV] = '{ 2,  2,  0, 1,  3, 7, 0, 2, 2,  1, 0,   0,    0,    4};
   localparam int VA [NV] = '{1280, 1600, 2560, 1280, 1112, 1103, 0, 16, 28, -146, 64,
                              32704, -32768, -32768};
   localparam int VF [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0};

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input int s, input int k);
      @(negedge clk);
      sample_in  = 10'(s);
      shift_k    = 3'(k);
      sample_vld = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      sample_vld = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      #1_000_000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      int prev;
      do_reset;
      // R1: reset state and idle before first reading
      check("R1 avg", avg_q, 0);
      check("R1 flag", window_throttled, 0);
      @(negedge clk);
      check("R1 idle avg", avg_q, 0);

      // R2 R3 R6 R8: vector table
      for (int i = 0; i < NV; i++) begin
         apply(VS[i], VK[i]);
         check($sformatf("R3/R8 vec%0d avg", i), avg_q, VA[i]);
         check($sformatf("R6 vec%0d flag", i), window_throttled, VF[i]);
      end

      // R5: invalid readings are ignored
      @(negedge clk);
      sample_in = 10'sd100; shift_k = 3'd0;
      repeat (3) @(negedge clk);
      check("R5 hold", avg_q, -32768);

      // R2: first reading loads exactly even with heavy shift
      do_reset;
      apply(7, 7);
      check("R2 first load", avg_q, 448);

      // R4: larger shift gives a smaller step
      do_reset;
      apply(0, 5);
      apply(10, 3);
      check("R4 k3 step", avg_q, 80);
      do_reset;
      apply(0, 5);
      apply(10, 1);
      check("R4 k1 step", avg_q, 320);

      // R7: fraction decays strictly to zero under zero readings
      do_reset;
      apply(1, 0);
      apply(0, 2);
      check("R7 start", avg_q, 48);
      check("R6 start flag", window_throttled, 1);
      prev = avg_q;
      for (int j = 0; j < 16 && prev != 0; j++) begin
         apply(0, 2);
         if (!(avg_q < prev)) check("R7 strict decrease", avg_q, prev - 1);
         prev = avg_q;
      end
      check("R7 reaches zero", avg_q, 0);
      check("R6 zero flag", window_throttled, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule